// File: doc/BRIEF.md
# Auto-Detecting Serial Control Port

This block is the slave end of a two-byte serial control link that gives a host processor access to a file of eight byte-wide configuration registers. Each transaction opens with chip select going low. The level of the serial clock at that moment chooses one of two host conventions for the whole transaction. With the clock idling high, the port uses one bidirectional data pin and moves bytes least significant bit first. With the clock idling low, it behaves as an SPI mode 0 slave: the receive and transmit pins are separate and bytes move most significant bit first.

The first byte is a command byte that carries a read/write flag and a register index. Its layout differs between the two conventions. The second byte is either the value to store or the value the port returns. The port samples incoming bits on the rising serial clock edge and changes its output bit on the falling edge. All serial pins are oversampled by a system clock that is much faster than the serial clock. Register index 3 is a control register that holds a software-reset flag in bit 7. While that flag is set, the other bits of the register are forced to zero.

Top module: `scp_ctrl_port`

## Requirements
- R1: If `sclk` is high when `cs_n` falls, the transaction uses single-pin mode. Bits are received on `data1_i`, `data2_i` is ignored, and both bytes travel least significant bit first.
- R2: If `sclk` is low when `cs_n` falls, the transaction uses two-pin mode. Bits are received on `data2_i`, `data1_i` is ignored, and both bytes travel most significant bit first.
- R3: In single-pin mode, command bit 0 is the read flag (1 = read, 0 = write) and command bits [3:1] hold the register index. Bits [7:4] are unused.
- R4: In two-pin mode, command bit 7 is the read flag (1 = read) and command bits [2:0] hold the register index. Bits [6:3] are unused.
- R5: After the 16th received bit of a write, `wr_stb` is high for exactly one system clock cycle, carrying `wr_addr` and `wr_data`. The addressed register holds the new value on the next cycle. No register changes at any other time.
- R6: On a read, the register value is captured when the command byte completes. It is presented on `data1_o` in the mode's bit order, with a new bit after each falling serial clock edge of the data byte, so the host can sample each bit on the following rising edge.
- R7: `data1_oe` is low while `cs_n` is high, throughout the command byte, and throughout any write transaction. It is high during the data byte of a read.
- R8: Serial clocks after the 16th bit do not start a new command and do not produce a second write. A transaction cut short by `cs_n` rising before 16 bits writes nothing.
- R9: Data received during the data byte of a read is discarded. No register changes.
- R10: Register 3, bit 7 is a software-reset flag. Writing the register with bit 7 set stores 0x80. While the flag is set, a write with bit 7 clear stores 0x00. Only when the flag is already clear does a write store the written value.
- R11: After `rst_n` is low for a clock edge, all registers read 0, and `wr_stb` and `data1_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| data1_i | input | 1 | Input side of the bidirectional data pin |
| data1_o | output | 1 | Output side of the bidirectional data pin |
| data1_oe | output | 1 | Output enable for the bidirectional data pin |
| data2_i | input | 1 | Receive-only data pin, used in two-pin mode |
| wr_stb | output | 1 | One-cycle write strobe toward the core |
| wr_addr | output | 3 | Register index of the write |
| wr_data | output | 8 | Value being written |
| regs_flat | output | 64 | All eight registers side by side, register i at bits [8i+7:8i] |

## Verification
Four properties are checked on every cycle: the pin driver stays off while chip select is high, the write strobe never lasts longer than one cycle or overlaps a driven pin, registers change only right after a strobe, and the reset flag never coexists with other set bits in the control register. Mode detection, the two command layouts, the bit order of returned data, and the discarding of extra or aborted clocks cannot be seen from a single cycle. Only the bench's full transactions can show them, by writing in one mode and reading back in the other.

// File: rtl/scp_pkg.sv
// Shared definitions for the serial control port.
// Assumes byte-wide registers; mode encoding equals the sclk level at CS fall.
package scp_pkg;
    typedef enum logic {
        MODE_MSB_FIRST = 1'b0,  // sclk low at select: two pins, MSB first
        MODE_LSB_FIRST = 1'b1   // sclk high at select: one pin, LSB first
    } scp_mode_e;
endpackage

// File: rtl/scp_edge_sync.sv
// Registers the asynchronous serial pins into the system clock domain and
// turns level changes into one-cycle edge pulses.
// Assumes sclk is slower than clk / 4 so that every level is seen.
module scp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic data1_i,
    input  logic data2_i,
    output logic cs_lvl,
    output logic sclk_lvl,
    output logic d1_lvl,
    output logic d2_lvl,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic cs_prev;
    logic sclk_prev;

    // Purpose: capture pin levels and keep the previous sample for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_lvl    <= 1'b1;
            cs_prev   <= 1'b1;
            sclk_lvl  <= 1'b0;
            sclk_prev <= 1'b0;
            d1_lvl    <= 1'b0;
            d2_lvl    <= 1'b0;
        end else begin
            cs_lvl    <= cs_n;
            cs_prev   <= cs_lvl;
            sclk_lvl  <= sclk;
            sclk_prev <= sclk_lvl;
            d1_lvl    <= data1_i;
            d2_lvl    <= data2_i;
        end
    end

    // Purpose: derive single-cycle edge pulses from consecutive samples.
    always_comb begin
        cs_fall   = cs_prev & ~cs_lvl;
        sclk_rise = ~sclk_prev & sclk_lvl;
        sclk_fall = sclk_prev & ~sclk_lvl;
    end
endmodule

// File: rtl/scp_serdes.sv
// Transaction engine: detects the host convention at select, assembles the
// command and data bytes, issues the write strobe and shifts read data out.
// Assumes edge pulses come from scp_edge_sync; reads rd_data combinationally.
module scp_serdes
    import scp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_fall,
    input  logic              sclk_lvl,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              d1_lvl,
    input  logic              d2_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              tx_bit,
    output logic              tx_en
);
    localparam int FRAME = 2 * DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_FST  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] FRAME_LST = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME);

    scp_mode_e         mode;
    logic              active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_sr;
    logic              is_read;
    logic [ADDR_W-1:0] addr_q;
    logic              rx_bit;
    logic              cmd_rw;
    logic [ADDR_W-1:0] cmd_addr;
    logic              shift_in;
    logic              shift_out;
    logic              in_data;

    // Purpose: pick the receive pin, the bit order and the command layout.
    always_comb begin
        rx_bit = (mode == MODE_LSB_FIRST) ? d1_lvl : d2_lvl;
        if (mode == MODE_LSB_FIRST) begin
            rx_next  = {rx_bit, rx_sr[DATA_W-1:1]};
            cmd_rw   = rx_next[0];
            cmd_addr = rx_next[ADDR_W:1];
        end else begin
            rx_next  = {rx_sr[DATA_W-2:0], rx_bit};
            cmd_rw   = rx_next[DATA_W-1];
            cmd_addr = rx_next[ADDR_W-1:0];
        end
        rd_addr   = cmd_addr;
        in_data   = (bit_cnt >= DATA_FST) && (bit_cnt < FRAME_END);
        shift_in  = active && !cs_lvl && sclk_rise && (bit_cnt < FRAME_END);
        shift_out = active && !cs_lvl && sclk_fall && is_read && in_data;
        tx_en     = active && !cs_lvl && is_read && (bit_cnt >= DATA_FST);
    end

    // Purpose: track the transaction, its mode and the received bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_MSB_FIRST;
            active  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            is_read <= 1'b0;
            addr_q  <= '0;
        end else if (cs_fall) begin
            mode    <= scp_mode_e'(sclk_lvl);
            active  <= 1'b1;
            bit_cnt <= '0;
            is_read <= 1'b0;
        end else if (cs_lvl) begin
            active  <= 1'b0;
        end else if (shift_in) begin
            rx_sr   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CMD_LAST) begin
                is_read <= cmd_rw;
                addr_q  <= cmd_addr;
            end
        end
    end

    // Purpose: one-cycle write strobe once the data byte of a write is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= shift_in && (bit_cnt == FRAME_LST) && !is_read;
            if (shift_in && (bit_cnt == FRAME_LST)) begin
                wr_addr <= addr_q;
                wr_data <= rx_next;
            end
        end
    end

    // Purpose: capture read data after the command and shift it on falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            tx_bit <= 1'b0;
        end else if (cs_fall) begin
            tx_bit <= 1'b0;
        end else if (shift_in && (bit_cnt == CMD_LAST)) begin
            tx_sr  <= rd_data;
        end else if (shift_out) begin
            if (mode == MODE_LSB_FIRST) begin
                tx_bit <= tx_sr[0];
                tx_sr  <= {1'b0, tx_sr[DATA_W-1:1]};
            end else begin
                tx_bit <= tx_sr[DATA_W-1];
                tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/scp_regfile.sv
// Register file of NREG words. One word holds a software-reset flag that
// forces its other bits to zero while set.
// Assumes at most one write per cycle; read port is combinational.
module scp_regfile #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int CTRL_IDX = 3,
    parameter int SRST_BIT = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);
    localparam int NREG = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] SRST_ONLY = DATA_W'(1) << SRST_BIT;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        if (i == CTRL_IDX) begin : g_ctrl
            // Purpose: control word; reset flag masks and blocks other bits.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (wr_stb && (wr_addr == IDX)) begin
                    if (wr_data[SRST_BIT])      regs[i] <= SRST_ONLY;
                    else if (regs[i][SRST_BIT]) regs[i] <= '0;
                    else                        regs[i] <= wr_data;
                end
            end
        end else begin : g_plain
            // Purpose: plain storage word.
            always_ff @(posedge clk) begin
                if (!rst_n)                             regs[i] <= '0;
                else if (wr_stb && (wr_addr == IDX))    regs[i] <= wr_data;
            end
        end
        assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/scp_ctrl_port.sv
// Top of the auto-detecting serial control port: pin sampling, transaction
// engine and register file. The bidirectional pin is split into in/out/enable.
// Assumes clk runs at least four times faster than sclk.
module scp_ctrl_port #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int CTRL_IDX = 3,
    parameter int SRST_BIT = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          sclk,
    input  logic                          data1_i,
    output logic                          data1_o,
    output logic                          data1_oe,
    input  logic                          data2_i,
    output logic                          wr_stb,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [DATA_W-1:0]             wr_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);
    logic cs_lvl, sclk_lvl, d1_lvl, d2_lvl;
    logic cs_fall, sclk_rise, sclk_fall;
    logic tx_bit, tx_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    scp_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .data1_i(data1_i), .data2_i(data2_i),
        .cs_lvl(cs_lvl), .sclk_lvl(sclk_lvl), .d1_lvl(d1_lvl), .d2_lvl(d2_lvl),
        .cs_fall(cs_fall), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    scp_serdes #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
        .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .d1_lvl(d1_lvl), .d2_lvl(d2_lvl), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_bit(tx_bit), .tx_en(tx_en)
    );

    scp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .CTRL_IDX(CTRL_IDX), .SRST_BIT(SRST_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(regs_flat)
    );

    // Purpose: drive the shared pin only while a read's data byte is out.
    always_comb begin
        data1_oe = tx_en;
        data1_o  = tx_en ? tx_bit : 1'b0;
    end
endmodule

// File: rtl/scp_ctrl_port_chk.sv
// Cycle-level properties of the serial control port, bound to its top.
// Assumes the same parameters as the bound instance.
module scp_ctrl_port_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int CTRL_IDX = 3,
    parameter int SRST_BIT = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_n,
    input logic                          data1_oe,
    input logic                          wr_stb,
    input logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);
    localparam logic [DATA_W-1:0] OTHER_BITS = ~(DATA_W'(1) << SRST_BIT);

    logic [DATA_W-1:0] ctrl_word;
    assign ctrl_word = regs_flat[CTRL_IDX*DATA_W +: DATA_W];

    assert_oe_off_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !data1_oe);

    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && data1_oe));

    assert_regs_change_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(regs_flat));

    assert_srst_masks_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[SRST_BIT] |-> ((ctrl_word & OTHER_BITS) == '0));
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX), .SRST_BIT(SRST_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .data1_oe(data1_oe),
    .wr_stb(wr_stb), .regs_flat(regs_flat)
);

// File: tb/scp_ctrl_port_bench.sv
// Self-checking bench: table-driven write/read-back across both modes,
// then directed reset and corner-case tests.
module scp_ctrl_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        data1_i = 1'b0;
    logic        data2_i = 1'b0;
    logic        data1_o, data1_oe, wr_stb;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [63:0] regs_flat;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [2:0] last_addr = '0;
    logic [7:0] last_data = '0;

    always #4 clk = ~clk;

    scp_ctrl_port u_scp_ctrl_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .data1_i(data1_i), .data1_o(data1_o), .data1_oe(data1_oe),
        .data2_i(data2_i), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    // Purpose: record each write strobe away from the active edge.
    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cmd(input bit lsb, input bit rd, input logic [2:0] a);
        return lsb ? {4'b0000, a, rd} : {rd, 4'b0000, a};
    endfunction

    // Host transaction: nbits clocks; bits past 16 send ~dat; garbage on unused pin.
    task automatic xfer(input bit lsb, input logic [7:0] cmd, input logic [7:0] dat,
                        input int nbits, output logic [7:0] rd,
                        output int oe_cmd, output int oe_dat);
        rd = '0; oe_cmd = 0; oe_dat = 0;
        sclk = lsb; tick(4);
        cs_n = 1'b0; tick(4);
        for (int i = 0; i < nbits; i++) begin
            int k = i % 8;
            int pos = lsb ? k : 7 - k;
            logic [7:0] src = (i < 8) ? cmd : ((i < 16) ? dat : ~dat);
            sclk = 1'b0;
            if (lsb) begin data1_i = src[pos]; data2_i = ~src[pos]; end
            else     begin data2_i = src[pos]; data1_i = ~src[pos]; end
            tick(4);
            if (i < 8 && data1_oe) oe_cmd++;
            if (i >= 8 && i < 16) begin
                if (data1_oe) oe_dat++;
                rd[pos] = data1_o;
            end
            sclk = 1'b1; tick(4);
        end
        if (!lsb) begin sclk = 1'b0; tick(4); end
        cs_n = 1'b1; tick(6);
    endtask

    // {write lsb, read lsb, addr, data}
    localparam logic [12:0] VEC [7] = '{
        {1'b1, 1'b0, 3'd0, 8'hA5},
        {1'b0, 1'b1, 3'd1, 8'h3C},
        {1'b1, 1'b1, 3'd2, 8'hFF},
        {1'b0, 1'b0, 3'd4, 8'h01},
        {1'b1, 1'b0, 3'd5, 8'h80},
        {1'b0, 1'b1, 3'd7, 8'h6E},
        {1'b1, 1'b0, 3'd6, 8'h96}
    };

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int oc, od, s0;
        tick(5);
        // R11: reset state
        chk("R11 regs after reset", 32'(regs_flat[31:0] | regs_flat[63:32]), 32'h0);
        chk("R11 oe after reset", 32'(data1_oe), 32'h0);
        chk("R11 strobe after reset", 32'(wr_stb), 32'h0);
        rst_n = 1'b1; tick(4);

        for (int v = 0; v < 7; v++) begin
            bit wl = VEC[v][12];
            bit rl = VEC[v][11];
            logic [2:0] a = VEC[v][10:8];
            logic [7:0] d = VEC[v][7:0];
            string wt = wl ? "R1 R3 R5" : "R2 R4 R5";
            string rt = rl ? "R1 R3 R6" : "R2 R4 R6";
            s0 = stb_cnt;
            xfer(wl, mk_cmd(wl, 1'b0, a), d, 16, rd, oc, od);
            chk({wt, " strobe count"}, 32'(stb_cnt - s0), 32'd1);
            chk({wt, " strobe addr"}, 32'(last_addr), 32'(a));
            chk({wt, " strobe data"}, 32'(last_data), 32'(d));
            chk({wt, " register"}, 32'(regs_flat[a*8 +: 8]), 32'(d));
            chk("R7 oe during write", 32'(oc + od), 32'd0);
            xfer(rl, mk_cmd(rl, 1'b1, a), 8'h00, 16, rd, oc, od);
            chk({rt, " read value"}, 32'(rd), 32'(d));
            chk("R7 oe in command byte", 32'(oc), 32'd0);
            chk("R7 oe in read data byte", 32'(od), 32'd8);
            chk("R7 oe after deselect", 32'(data1_oe), 32'd0);
        end

        // R8: extra clocks after the second byte
        s0 = stb_cnt;
        xfer(1'b1, mk_cmd(1'b1, 1'b0, 3'd6), 8'h33, 24, rd, oc, od);
        chk("R8 single strobe with extra clocks", 32'(stb_cnt - s0), 32'd1);
        chk("R8 register keeps second byte", 32'(regs_flat[48 +: 8]), 32'h33);
        s0 = stb_cnt;
        xfer(1'b0, mk_cmd(1'b0, 1'b0, 3'd6), 8'h44, 24, rd, oc, od);
        chk("R8 single strobe two-pin mode", 32'(stb_cnt - s0), 32'd1);
        chk("R8 register two-pin mode", 32'(regs_flat[48 +: 8]), 32'h44);

        // R8: aborted transaction
        s0 = stb_cnt;
        xfer(1'b0, mk_cmd(1'b0, 1'b0, 3'd6), 8'hEE, 12, rd, oc, od);
        chk("R8 abort gives no strobe", 32'(stb_cnt - s0), 32'd0);
        chk("R8 abort leaves register", 32'(regs_flat[48 +: 8]), 32'h44);

        // R9: incoming bits during read are ignored
        s0 = stb_cnt;
        xfer(1'b0, mk_cmd(1'b0, 1'b1, 3'd6), 8'hFF, 16, rd, oc, od);
        chk("R9 no strobe on read", 32'(stb_cnt - s0), 32'd0);
        chk("R9 register unchanged", 32'(regs_flat[48 +: 8]), 32'h44);
        chk("R9 read value", 32'(rd), 32'h44);

        // R10: software reset flag in register 3
        xfer(1'b1, mk_cmd(1'b1, 1'b0, 3'd3), 8'h5A, 16, rd, oc, od);
        chk("R10 plain write while clear", 32'(regs_flat[24 +: 8]), 32'h5A);
        xfer(1'b0, mk_cmd(1'b0, 1'b0, 3'd3), 8'hC3, 16, rd, oc, od);
        chk("R10 set flag masks bits", 32'(regs_flat[24 +: 8]), 32'h80);
        xfer(1'b1, mk_cmd(1'b1, 1'b0, 3'd3), 8'h7F, 16, rd, oc, od);
        chk("R10 write while set only clears", 32'(regs_flat[24 +: 8]), 32'h00);
        xfer(1'b0, mk_cmd(1'b0, 1'b0, 3'd3), 8'h7F, 16, rd, oc, od);
        chk("R10 second write lands", 32'(regs_flat[24 +: 8]), 32'h7F);
        xfer(1'b1, mk_cmd(1'b1, 1'b1, 3'd3), 8'h00, 16, rd, oc, od);
        chk("R10 R6 read back control", 32'(rd), 32'h7F);

        // R11: reset mid-life clears everything
        rst_n = 1'b0; tick(2);
        chk("R11 regs after second reset", 32'(regs_flat[31:0] | regs_flat[63:32]), 32'h0);
        rst_n = 1'b1; tick(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule